// File: doc/BRIEF.md
# Tagged Fan-In / Fan-Out Compute Pipeline

This block lets several requesters share a single multi-stage compute pipeline. Each input port offers a request (operands plus a one-bit operation select) under a valid/ready handshake. A round-robin arbiter admits one request per cycle. The number of the admitting port is attached to the request as a source tag. That tag rides unchanged through every pipeline stage. At the exit it picks the output port that receives the result. Each output port has its own valid/ready handshake, and a stalled output holds its result and backs up the shared pipe.

The operation is deliberately trivial. In two-operand builds it adds or subtracts. In single-operand builds it inverts or increments the first operand and ignores the second. The block may route results onto the upper part of its output ports only. In that case a request tagged `k` leaves on output `NPORT-NROUTE+k`, and only the lowest `NROUTE` inputs are served. A per-port cancel line removes every in-flight item carrying that port's tag and blocks new requests from that port while it is high.

Top module: `tagged_fanio_pipe`

## Requirements
- R1: In a cycle where several served inputs are valid and the pipe can accept, exactly one `in_ready` bit is high, and only on a valid port. After reset the grant order starts at port 0, and after each grant the search restarts at the port just above the one granted, wrapping to 0.
- R2: `in_ready` is never high for an input port at or above `NROUTE`, nor for a port whose `cancel_i` bit is high.
- R3: In two-operand mode (`SINGLE_OP=0`), the result is `a+b` when the port's `in_op` bit is 0 and `a-b` when it is 1, both modulo 2^DW.
- R4: In single-operand mode (`SINGLE_OP=1`), the result is `~a` when `in_op` is 0 and `a+1` when it is 1. Operand `b` has no effect on the result.
- R5: A request accepted on input `k` appears only on output `NPORT-NROUTE+k`, with `out_id` equal to `k`. At most one `out_valid` bit is high at a time, and outputs below `NPORT-NROUTE` never assert valid.
- R6: With no stall, a request accepted at a clock edge shows `out_valid` after `DEPTH-1` further clock edges.
- R7: While an output shows valid and its `out_ready` is low, it keeps valid and the same `out_z` in the next cycle, unless a cancel arrives.
- R8: Results from one input leave on their output port in the order they were accepted.
- R9: In a cycle where `cancel_i[k]` is high, no output shows an item tagged `k`. Items tagged `k` that were in flight before that edge never transfer. Items from other ports move on and arrive intact.
- R10: Immediately after reset, with no input valid, all `out_valid` and `in_ready` bits are low.
- R11: With all outputs ready, the pipe accepts one request in every cycle, with no bubbles.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | NPORT | Request valid per input port |
| in_ready | output | NPORT | Request accepted per input port |
| in_a | input | NPORT*DW | First operand, DW bits per port |
| in_b | input | NPORT*DW | Second operand, DW bits per port |
| in_op | input | NPORT | Operation select per port |
| cancel_i | input | NPORT | Kill in-flight items of that port's tag |
| out_valid | output | NPORT | Result valid per output port |
| out_ready | input | NPORT | Result taken per output port |
| out_z | output | NPORT*DW | Result, same value on every output slice |
| out_id | output | NPORT*IDW | Source tag of the result, IDW = clog2(NPORT) |

## Verification
Two things can meet in the same cycle: a cancel for the port whose result is stalled at the head of the pipe, and the advance of another port's item queued behind it. The bench blocks one output so that its item parks at the exit with a different port's item one stage back. It then raises that port's cancel, together with a fresh request on the same port. Correct handling means the parked result disappears at once, the new request is refused, and on the very next cycle the other port's result appears with its own tag and value. The cancelled item must also never show up again after its output is released.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

   typedef enum logic {
      OP_MAIN = 1'b0,
      OP_ALT  = 1'b1
   } op_sel_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tfp_rr_arb.sv
module tfp_rr_arb #(
   parameter int N  = 4,
   parameter int PW = tfp_pkg::idx_width(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic [N-1:0]  grant,
   output logic [PW-1:0] win,
   output logic          any
);

   logic [PW-1:0] ptr;

   always_comb begin
      int idx;
      grant = '0;
      win   = '0;
      any   = 1'b0;
      for (int off = 0; off < N; off++) begin
         idx = int'(ptr) + off;
         if (idx >= N) idx = idx - N;
         if (!any && req[idx]) begin
            any        = 1'b1;
            grant[idx] = 1'b1;
            win        = PW'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv && any) begin
         ptr <= (win == PW'(N-1)) ? '0 : win + 1'b1;
      end
   end

endmodule

// File: rtl/tfp_op_unit.sv
module tfp_op_unit #(
   parameter int DW        = 16,
   parameter bit SINGLE_OP = 1'b0
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          op,
   output logic [DW-1:0] z
);

   generate
      if (SINGLE_OP) begin : g_unary
         logic unused_b;
         assign unused_b = ^b;
         assign z = (op == tfp_pkg::OP_ALT) ? a + DW'(1) : ~a;
      end else begin : g_binary
         assign z = (op == tfp_pkg::OP_ALT) ? a - b : a + b;
      end
   endgenerate

endmodule

// File: rtl/tfp_stage.sv
module tfp_stage #(
   parameter int DW  = 16,
   parameter int IDW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           d_vld,
   input  logic [DW-1:0]  d_z,
   input  logic [IDW-1:0] d_id,
   output logic           q_vld,
   output logic [DW-1:0]  q_z,
   output logic [IDW-1:0] q_id
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld <= 1'b0;
         q_z   <= '0;
         q_id  <= '0;
      end else if (load) begin
         q_vld <= d_vld;
         q_z   <= d_z;
         q_id  <= d_id;
      end
   end

endmodule

// File: rtl/tagged_fanio_pipe.sv
module tagged_fanio_pipe #(
   parameter int NPORT     = 4,
   parameter int NROUTE    = 4,
   parameter int DW        = 16,
   parameter int DEPTH     = 3,
   parameter bit SINGLE_OP = 1'b0,
   parameter int IDW       = tfp_pkg::idx_width(NPORT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPORT-1:0]     in_valid,
   output logic [NPORT-1:0]     in_ready,
   input  logic [NPORT*DW-1:0]  in_a,
   input  logic [NPORT*DW-1:0]  in_b,
   input  logic [NPORT-1:0]     in_op,
   input  logic [NPORT-1:0]     cancel_i,
   output logic [NPORT-1:0]     out_valid,
   input  logic [NPORT-1:0]     out_ready,
   output logic [NPORT*DW-1:0]  out_z,
   output logic [NPORT*IDW-1:0] out_id
);

   localparam int OFFSET = NPORT - NROUTE;
   localparam int LAST   = DEPTH - 1;
   localparam int RW     = tfp_pkg::idx_width(NROUTE);

   generate
      if (NPORT < 2) begin : g_chk_nport
         $error("tagged_fanio_pipe: NPORT must be at least 2");
      end
      if (NROUTE < 1 || NROUTE > NPORT) begin : g_chk_nroute
         $error("tagged_fanio_pipe: NROUTE must lie in 1..NPORT");
      end
      if (DEPTH < 1) begin : g_chk_depth
         $error("tagged_fanio_pipe: DEPTH must be at least 1");
      end
      if (DW < 1) begin : g_chk_dw
         $error("tagged_fanio_pipe: DW must be at least 1");
      end
      if (IDW < tfp_pkg::idx_width(NPORT)) begin : g_chk_idw
         $error("tagged_fanio_pipe: IDW too narrow for NPORT");
      end
   endgenerate

   // ---------------- fan-in ----------------
   logic [NROUTE-1:0] arb_req;
   logic [NROUTE-1:0] arb_grant;
   logic [RW-1:0]     arb_win;
   logic              arb_any;
   logic [DW-1:0]     sel_a;
   logic [DW-1:0]     sel_b;
   logic              sel_op;
   logic [DW-1:0]     entry_z;

   // pipeline state
   logic [DEPTH-1:0] s_vld;
   logic [DEPTH-1:0] s_ev;
   logic [DEPTH-1:0] s_rdy;
   logic [DW-1:0]    s_z  [DEPTH];
   logic [IDW-1:0]   s_id [DEPTH];
   logic [DEPTH-1:0] d_vld;
   logic [DW-1:0]    d_z  [DEPTH];
   logic [IDW-1:0]   d_id [DEPTH];
   logic             dest_ready;

   genvar gk;
   generate
      for (gk = 0; gk < NPORT; gk++) begin : g_in
         if (gk < NROUTE) begin : g_served
            assign arb_req[gk]  = in_valid[gk] & ~cancel_i[gk];
            assign in_ready[gk] = arb_grant[gk] & s_rdy[0];
         end else begin : g_idle
            assign in_ready[gk] = 1'b0;
         end
      end
   endgenerate

   tfp_rr_arb #(
      .N  (NROUTE),
      .PW (RW)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (arb_req),
      .adv   (s_rdy[0]),
      .grant (arb_grant),
      .win   (arb_win),
      .any   (arb_any)
   );

   assign sel_a  = in_a[arb_win*DW +: DW];
   assign sel_b  = in_b[arb_win*DW +: DW];
   assign sel_op = in_op[arb_win];

   tfp_op_unit #(
      .DW        (DW),
      .SINGLE_OP (SINGLE_OP)
   ) u_op (
      .a  (sel_a),
      .b  (sel_b),
      .op (sel_op),
      .z  (entry_z)
   );

   // ---------------- shared pipe ----------------
   genvar gs;
   generate
      for (gs = 0; gs < DEPTH; gs++) begin : g_stage
         assign s_ev[gs] = s_vld[gs] & ~cancel_i[s_id[gs]];

         if (gs == 0) begin : g_head
            assign d_vld[gs] = arb_any;
            assign d_z[gs]   = entry_z;
            assign d_id[gs]  = IDW'(arb_win);
         end else begin : g_body
            assign d_vld[gs] = s_ev[gs-1];
            assign d_z[gs]   = s_z[gs-1];
            assign d_id[gs]  = s_id[gs-1];
         end

         if (gs == LAST) begin : g_tail_rdy
            assign s_rdy[gs] = ~s_ev[gs] | dest_ready;
         end else begin : g_mid_rdy
            assign s_rdy[gs] = ~s_ev[gs] | s_rdy[gs+1];
         end

         tfp_stage #(
            .DW  (DW),
            .IDW (IDW)
         ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (s_rdy[gs]),
            .d_vld (d_vld[gs]),
            .d_z   (d_z[gs]),
            .d_id  (d_id[gs]),
            .q_vld (s_vld[gs]),
            .q_z   (s_z[gs]),
            .q_id  (s_id[gs])
         );
      end
   endgenerate

   // ---------------- fan-out ----------------
   always_comb begin
      dest_ready = 1'b0;
      for (int j = 0; j < NPORT; j++) begin
         if (j >= OFFSET && s_id[LAST] == IDW'(j - OFFSET)) begin
            dest_ready = out_ready[j];
         end
      end
   end

   genvar go;
   generate
      for (go = 0; go < NPORT; go++) begin : g_out
         if (go < OFFSET) begin : g_unrouted
            assign out_valid[go] = 1'b0;
         end else begin : g_routed
            assign out_valid[go] = s_ev[LAST] & (s_id[LAST] == IDW'(go - OFFSET));
         end
         assign out_z[go*DW +: DW]   = s_z[LAST];
         assign out_id[go*IDW +: IDW] = s_id[LAST];
      end
   endgenerate

endmodule

// File: rtl/tfp_checker.sv
module tfp_checker #(
   parameter int NPORT  = 4,
   parameter int NROUTE = 4,
   parameter int DW     = 16,
   parameter int IDW    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NPORT-1:0]     in_valid,
   input logic [NPORT-1:0]     in_ready,
   input logic [NPORT-1:0]     cancel_i,
   input logic [NPORT-1:0]     out_valid,
   input logic [NPORT-1:0]     out_ready,
   input logic [NPORT*DW-1:0]  out_z,
   input logic [NPORT*IDW-1:0] out_id
);

   localparam int OFFSET = NPORT - NROUTE;

   assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   assert_grant_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready & ~in_valid) == '0);

   assert_cancel_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready & cancel_i) == '0);

   assert_out_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));

   genvar gj;
   generate
      for (gj = 0; gj < NPORT; gj++) begin : g_port
         if (gj >= NROUTE) begin : g_unserved
            assert_unrouted_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
               !in_ready[gj]);
         end else begin : g_served
            assert_cancel_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
               cancel_i[gj] |=> !out_valid[OFFSET+gj]);
         end

         if (gj < OFFSET) begin : g_low
            assert_low_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
               !out_valid[gj]);
         end else begin : g_high
            assert_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
               out_valid[gj] |-> (out_id[gj*IDW +: IDW] == IDW'(gj - OFFSET)));

            assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
               (out_valid[gj] && !out_ready[gj]) |=>
                  ((|cancel_i) || (out_valid[gj] && $stable(out_z[gj*DW +: DW]))));
         end
      end
   endgenerate

endmodule

bind tagged_fanio_pipe tfp_checker #(
   .NPORT  (NPORT),
   .NROUTE (NROUTE),
   .DW     (DW),
   .IDW    (IDW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .cancel_i  (cancel_i),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_z     (out_z),
   .out_id    (out_id)
);

// File: tb/tagged_fanio_pipe_tb_top.sv
`timescale 1ns/1ps
module tagged_fanio_pipe_tb_top;

   localparam int NP    = 4;
   localparam int DW    = 16;
   localparam int IW    = 2;
   localparam int DEPTH = 3;

   typedef struct packed {
      logic [1:0]  p;
      logic [15:0] a;
      logic [15:0] b;
      logic        op;
   } vec_t;

   // port, a, b, op ; expected z computed from R3
   localparam vec_t VECS [8] = '{
      '{2'd0, 16'h0001, 16'h0002, 1'b0},
      '{2'd1, 16'hFFFF, 16'h0001, 1'b0},
      '{2'd2, 16'h1234, 16'h0234, 1'b1},
      '{2'd3, 16'h0000, 16'h0001, 1'b1},
      '{2'd1, 16'h8000, 16'h8000, 1'b0},
      '{2'd3, 16'hABCD, 16'h1111, 1'b0},
      '{2'd0, 16'h5555, 16'hAAAA, 1'b1},
      '{2'd2, 16'h7FFF, 16'h0001, 1'b0}
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic [NP-1:0]    iv, ir, iop, cx, ov, ordy;
   logic [NP*DW-1:0] ia, ib, oz;
   logic [NP*IW-1:0] oid;
   logic [NP-1:0]    iv2, ir2, iop2, cx2, ov2, ordy2;
   logic [NP*DW-1:0] ia2, ib2, oz2;
   logic [NP*IW-1:0] oid2;

   tagged_fanio_pipe #(.NPORT(NP), .NROUTE(NP), .DW(DW), .DEPTH(DEPTH), .SINGLE_OP(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_ready(ir), .in_a(ia), .in_b(ib),
      .in_op(iop), .cancel_i(cx), .out_valid(ov), .out_ready(ordy), .out_z(oz), .out_id(oid));

   tagged_fanio_pipe #(.NPORT(NP), .NROUTE(2), .DW(DW), .DEPTH(DEPTH), .SINGLE_OP(1'b1)) dut2_i (
      .clk(clk), .rst_n(rst_n), .in_valid(iv2), .in_ready(ir2), .in_a(ia2), .in_b(ib2),
      .in_op(iop2), .cancel_i(cx2), .out_valid(ov2), .out_ready(ordy2), .out_z(oz2), .out_id(oid2));

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input string rq, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic g_ir(input bit d2, input int p);
      return d2 ? ir2[p] : ir[p];
   endfunction
   function automatic logic g_ov(input bit d2, input int j);
      return d2 ? ov2[j] : ov[j];
   endfunction
   function automatic logic [DW-1:0] g_z(input bit d2, input int j);
      return d2 ? oz2[j*DW +: DW] : oz[j*DW +: DW];
   endfunction
   function automatic logic [IW-1:0] g_id(input bit d2, input int j);
      return d2 ? oid2[j*IW +: IW] : oid[j*IW +: IW];
   endfunction
   function automatic int g_cnt(input bit d2);
      return d2 ? $countones(ov2) : $countones(ov);
   endfunction

   // one request, waited through to its output
   task automatic xfer(input bit d2, input int p, input logic [15:0] a, input logic [15:0] b,
                       input logic op, input int dest, input logic [15:0] ez, input string rq);
      int n;
      int guard;
      @(negedge clk);
      if (d2) begin
         iv2[p] = 1'b1; ia2[p*DW +: DW] = a; ib2[p*DW +: DW] = b; iop2[p] = op;
      end else begin
         iv[p] = 1'b1; ia[p*DW +: DW] = a; ib[p*DW +: DW] = b; iop[p] = op;
      end
      #1;
      guard = 0;
      while (!g_ir(d2, p) && guard < 50) begin
         @(negedge clk); #1; guard++;
      end
      chk("R1", "request accepted", g_ir(d2, p), 1);
      @(posedge clk);
      @(negedge clk);
      if (d2) iv2[p] = 1'b0; else iv[p] = 1'b0;
      #1;
      n = 0;
      while (!g_ov(d2, dest) && n < 20) begin
         @(negedge clk); #1; n++;
      end
      chk("R6", "latency in cycles", n, DEPTH-1);
      chk(rq, "result z", g_z(d2, dest), ez);
      chk("R5", "output tag", g_id(d2, dest), p);
      chk("R5", "single valid output", g_cnt(d2), 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      iv = '0; iv2 = '0; cx = '0; cx2 = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // in-order monitor for the arbitration run (R8)
   logic mon_on = 1'b0;
   int   rseq [NP];
   always @(negedge clk) begin
      #2;
      if (mon_on) begin
         for (int j = 0; j < NP; j++) begin
            if (ov[j] && ordy[j]) begin
               chk("R8", "in-order value", oz[j*DW +: DW], {8'(j), 8'(rseq[j])});
               chk("R5", "monitor tag", oid[j*IW +: IW], j);
               rseq[j]++;
            end
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int sseq [NP];
      rst_n = 1'b0;
      iv = '0; ia = '0; ib = '0; iop = '0; cx = '0; ordy = '1;
      iv2 = '0; ia2 = '0; ib2 = '0; iop2 = '0; cx2 = '0; ordy2 = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10", "out_valid after reset", ov, 0);
      chk("R10", "in_ready after reset", ir, 0);
      chk("R10", "out_valid after reset (subset build)", ov2, 0);

      // table walk: R3, R5, R6
      for (int v = 0; v < 8; v++) begin
         logic [15:0] ez;
         ez = VECS[v].op ? VECS[v].a - VECS[v].b : VECS[v].a + VECS[v].b;
         xfer(1'b0, int'(VECS[v].p), VECS[v].a, VECS[v].b, VECS[v].op, int'(VECS[v].p), ez, "R3");
      end

      // round robin with all ports valid: R1, R11, R8
      do_reset();
      for (int p = 0; p < NP; p++) begin
         sseq[p] = 0;
         rseq[p] = 0;
         ia[p*DW +: DW] = {8'(p), 8'(0)};
         ib[p*DW +: DW] = '0;
         iop[p] = 1'b0;
      end
      mon_on = 1'b1;
      @(negedge clk);
      iv = '1;
      for (int c = 0; c < 8; c++) begin
         int g;
         #1;
         chk("R1", "round-robin grant", ir, 1 << (c % NP));
         chk("R11", "accept every cycle", |ir, 1);
         @(negedge clk);
         g = c % NP;
         sseq[g]++;
         ia[g*DW +: DW] = {8'(g), 8'(sseq[g])};
      end
      iv = '0;
      repeat (8) @(negedge clk);
      mon_on = 1'b0;
      for (int p = 0; p < NP; p++) chk("R8", "results per port", rseq[p], 2);

      // stalled output holds: R7
      @(negedge clk);
      ordy[1] = 1'b0;
      iv[1] = 1'b1; ia[1*DW +: DW] = 16'h0101; ib[1*DW +: DW] = 16'h0001; iop[1] = 1'b0;
      #1;
      chk("R1", "stall item accepted", ir[1], 1);
      @(posedge clk);
      @(negedge clk);
      iv[1] = 1'b0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 5; k++) begin
         #1;
         chk("R7", "held valid", ov[1], 1);
         chk("R7", "held z", oz[1*DW +: DW], 16'h0102);
         @(negedge clk);
      end
      ordy[1] = 1'b1;
      #1;
      chk("R7", "still valid at release", ov[1], 1);
      @(negedge clk);
      #1;
      chk("R7", "consumed after release", ov[1], 0);

      // cancel of stalled head with another port queued behind: R9, R2
      @(negedge clk);
      ordy[2] = 1'b0;
      iv[2] = 1'b1; ia[2*DW +: DW] = 16'h2222; ib[2*DW +: DW] = '0; iop[2] = 1'b0;
      #1;
      chk("R1", "port 2 item accepted", ir[2], 1);
      @(negedge clk);
      iv[2] = 1'b0;
      iv[3] = 1'b1; ia[3*DW +: DW] = 16'h3333; ib[3*DW +: DW] = '0; iop[3] = 1'b0;
      #1;
      chk("R1", "port 3 item accepted", ir[3], 1);
      @(negedge clk);
      iv[3] = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R7", "port 2 head parked", ov[2], 1);
      chk("R9", "port 3 waits behind", ov[3], 0);
      @(negedge clk);
      cx[2] = 1'b1;
      iv[2] = 1'b1;
      #1;
      chk("R9", "cancelled head hidden", ov[2], 0);
      chk("R2", "cancelled port refused", ir[2], 0);
      @(negedge clk);
      cx[2] = 1'b0;
      iv[2] = 1'b0;
      #1;
      chk("R9", "other port advances", ov[3], 1);
      chk("R9", "other port value", oz[3*DW +: DW], 16'h3333);
      chk("R9", "cancelled item gone", ov[2], 0);
      ordy[2] = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         #1;
         chk("R9", "cancelled item never returns", ov[2], 0);
      end

      // subset routing and single-operand build: R4, R5, R2
      xfer(1'b1, 1, 16'h00FF, 16'h1234, 1'b1, 3, 16'h0100, "R4");
      xfer(1'b1, 1, 16'h00FF, 16'hFFFF, 1'b1, 3, 16'h0100, "R4");
      xfer(1'b1, 0, 16'h0F0F, 16'h5A5A, 1'b0, 2, 16'hF0F0, "R4");
      @(negedge clk);
      iv2[3] = 1'b1;
      iv2[2] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk("R2", "unserved inputs refused", ir2, 0);
         @(negedge clk);
      end
      iv2 = '0;
      #1;
      chk("R5", "no stray output", ov2, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule